// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This unit collects interrupt events for a multi-channel DMA controller. Every channel reports five kinds of event: transfer done, block done, source transaction done, destination transaction done and bus error. For each kind the unit keeps three vectors with one bit per channel. The first is a sticky raw vector that records events whatever the masking. The second is a software-written enable mask. The third is a masked status vector, equal to raw AND mask. A write-one-to-clear register removes a pending bit from both the raw and the status vector in the same cycle. When an event and a clear hit the same bit in the same cycle, the event wins.

Each kind drives one interrupt line, which is the OR of its status bits over all channels. A summary register shows which kinds have anything pending. Transaction-done events are dropped for a channel whose source or destination is memory, because transaction levels mean nothing there. A bus-error event also produces a one-cycle abort request to that channel, which tells the transfer engine to cancel the transfer and disable the channel.

Software uses a small register port with a combinational read path. An optional error response flags any access to an unmapped address.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset, every raw and mask bit is 0, every interrupt line is low and `ch_abort` is 0.
- R2: An event pulse on channel c of a kind sets raw bit c of that kind on the next clock edge, whatever the mask. The bit stays set until it is cleared.
- R3: The mask registers can be written and read back. The status register of a kind reads as raw AND mask.
- R4: Each interrupt line is high exactly when some status bit of its kind is set. It changes in the same cycle as the raw and mask bits behind it.
- R5: Writing a 1 to bit c of a clear register clears raw bit c, and therefore status bit c, of that kind on that clock edge. Bits written 0 are left unchanged.
- R6: If an event and a clear reach the same bit in the same cycle, the bit ends up set.
- R7: A source-transaction event on channel c is ignored while `src_is_mem[c]` is 1. A destination-transaction event on channel c is ignored while `dst_is_mem[c]` is 1.
- R8: An error event on channel c drives `ch_abort[c]` high for the cycle that follows each cycle in which the event is present. At all other times `ch_abort[c]` is low.
- R9: The summary register at address 0x0F holds the interrupt line of kind k in bit k. All other bits are 0.
- R10: The address layout is as follows. `reg_addr[4:3]` selects the register: 0 raw, 1 status, 2 mask, 3 clear. `reg_addr[2:0]` selects the kind: 0 transfer, 1 block, 2 source transaction, 3 destination transaction, 4 error. Channel c uses data bit c, and all other bits read as 0. Reads of a clear register return 0. Writes to raw, status or summary addresses have no effect.
- R11: With `ERR_ON_ILLEGAL` = 1, an access to an address whose kind field is 5 to 7, other than 0x0F, raises `reg_err` in the same cycle. Legal accesses never raise it. With the parameter at 0, `reg_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_tfr | input | N | Transfer-done event pulses, one per channel |
| ev_block | input | N | Block-done event pulses |
| ev_src_tran | input | N | Source transaction-done event pulses |
| ev_dst_tran | input | N | Destination transaction-done event pulses |
| ev_err | input | N | Bus-error event pulses |
| src_is_mem | input | N | Channel source is memory |
| dst_is_mem | input | N | Channel destination is memory |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the access cycle |
| reg_err | output | 1 | Error response for an unmapped address |
| irq_tfr | output | 1 | Transfer-done interrupt |
| irq_block | output | 1 | Block-done interrupt |
| irq_src_tran | output | 1 | Source transaction interrupt |
| irq_dst_tran | output | 1 | Destination transaction interrupt |
| irq_err | output | 1 | Error interrupt |
| ch_abort | output | N | Per-channel cancel-and-disable request |

## Verification
The hardest case to reach from the ports is an event and a clear landing on the same bit in the same clock cycle. The bench reaches it by driving the clear write and the event pulse on the same falling edge, so that one rising edge samples both. It then reads the raw vector back. The memory-endpoint suppression is swept over every combination of memory flags and event patterns. Every mask value is paired with every event pattern for each kind, so each status value and each interrupt line level is reached.

// File: rtl/dma_irq_pkg.sv
// Package: shared constants and encodings for the DMA interrupt status unit.
// Assumes: five interrupt kinds; the kind code doubles as the address field
// and as the bit position in the summary register.
package dma_irq_pkg;

    localparam int NUM_KINDS  = 5;
    localparam int REG_ADDR_W = 5;

    typedef enum logic [2:0] {
        K_TFR   = 3'd0,
        K_BLOCK = 3'd1,
        K_SRC   = 3'd2,
        K_DST   = 3'd3,
        K_ERR   = 3'd4
    } irq_kind_e;

    typedef enum logic [1:0] {
        RK_RAW    = 2'd0,
        RK_STATUS = 2'd1,
        RK_MASK   = 2'd2,
        RK_CLEAR  = 2'd3
    } reg_kind_e;

    localparam logic [REG_ADDR_W-1:0] SUMMARY_ADDR = 5'h0F;

endpackage

// File: rtl/dma_irq_bank.sv
// Module: dma_irq_bank
// One interrupt kind: a sticky raw vector, a mask vector and the masked
// status vector, plus the OR-reduced interrupt line.
// Assumes: ev is already qualified; clr_we and mask_we are single-cycle
// strobes from the register decoder; an event beats a clear on the same bit.
module dma_irq_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         mask_we,
    input  logic         clr_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] status_o,
    output logic         any_o
);

    logic [N-1:0] raw_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] clr_vec;

    // Clear vector is active only on a clear strobe.
    assign clr_vec = clr_we ? wdata : '0;

    // Raw vector: clear the written ones, then OR in new events (event wins).
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_vec) | ev;
    end

    // Mask vector: loaded on a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    // Status and line follow raw and mask in the same cycle.
    assign status_o = raw_q & mask_q;
    assign any_o    = |status_o;
    assign raw_o    = raw_q;
    assign mask_o   = mask_q;

endmodule

// File: rtl/dma_irq_regif.sv
// Module: dma_irq_regif
// Register decoder: turns the access port into per-kind mask and clear
// strobes, muxes read data, and flags unmapped addresses.
// Assumes: reads are combinational in the access cycle; N <= DATA_W.
module dma_irq_regif
    import dma_irq_pkg::*;
#(
    parameter int N              = 4,
    parameter int DATA_W         = 32,
    parameter bit ERR_ON_ILLEGAL = 1'b1
) (
    input  logic                           reg_en,
    input  logic                           reg_we,
    input  logic [REG_ADDR_W-1:0]          reg_addr,
    input  logic [NUM_KINDS-1:0][N-1:0]    raw_all,
    input  logic [NUM_KINDS-1:0][N-1:0]    mask_all,
    input  logic [NUM_KINDS-1:0][N-1:0]    status_all,
    input  logic [NUM_KINDS-1:0]           any_all,
    output logic [NUM_KINDS-1:0]           mask_we,
    output logic [NUM_KINDS-1:0]           clr_we,
    output logic [DATA_W-1:0]              reg_rdata,
    output logic                           reg_err
);

    reg_kind_e  rkind;
    logic [2:0] ksel;
    logic       kind_ok;
    logic       sum_hit;

    assign rkind   = reg_kind_e'(reg_addr[4:3]);
    assign ksel    = reg_addr[2:0];
    assign kind_ok = (ksel < 3'(NUM_KINDS));
    assign sum_hit = (reg_addr == SUMMARY_ADDR);

    // Per-kind write strobes for mask and clear registers.
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_strobe
        assign mask_we[k] = reg_en && reg_we && (rkind == RK_MASK)  && (ksel == 3'(k));
        assign clr_we[k]  = reg_en && reg_we && (rkind == RK_CLEAR) && (ksel == 3'(k));
    end

    // Read data mux; clear registers and unmapped addresses read as zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_en && !reg_we) begin
            if (sum_hit) begin
                reg_rdata[NUM_KINDS-1:0] = any_all;
            end else if (kind_ok) begin
                case (rkind)
                    RK_RAW:    reg_rdata[N-1:0] = raw_all[ksel];
                    RK_STATUS: reg_rdata[N-1:0] = status_all[ksel];
                    RK_MASK:   reg_rdata[N-1:0] = mask_all[ksel];
                    RK_CLEAR:  reg_rdata        = '0;
                endcase
            end
        end
    end

    // Error response for unmapped addresses, only when enabled.
    assign reg_err = ERR_ON_ILLEGAL && reg_en && !kind_ok && !sum_hit;

endmodule

// File: rtl/dma_irq_unit.sv
// Module: dma_irq_unit (top)
// Interrupt status unit for an N-channel DMA controller: five interrupt
// kinds with raw/mask/status/clear per kind, one line per kind, a summary
// register and a per-channel abort request on bus error.
// Assumes: event inputs are single-cycle pulses from the channel engines;
// memory flags are levels that are stable while a channel is active.
module dma_irq_unit
    import dma_irq_pkg::*;
#(
    parameter int N              = 4,
    parameter int DATA_W         = 32,
    parameter bit ERR_ON_ILLEGAL = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          ev_tfr,
    input  logic [N-1:0]          ev_block,
    input  logic [N-1:0]          ev_src_tran,
    input  logic [N-1:0]          ev_dst_tran,
    input  logic [N-1:0]          ev_err,
    input  logic [N-1:0]          src_is_mem,
    input  logic [N-1:0]          dst_is_mem,
    input  logic                  reg_en,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  reg_err,
    output logic                  irq_tfr,
    output logic                  irq_block,
    output logic                  irq_src_tran,
    output logic                  irq_dst_tran,
    output logic                  irq_err,
    output logic [N-1:0]          ch_abort
);

    logic [NUM_KINDS-1:0][N-1:0] ev_q;
    logic [NUM_KINDS-1:0][N-1:0] raw_all;
    logic [NUM_KINDS-1:0][N-1:0] mask_all;
    logic [NUM_KINDS-1:0][N-1:0] status_all;
    logic [NUM_KINDS-1:0]        any_all;
    logic [NUM_KINDS-1:0]        mask_we;
    logic [NUM_KINDS-1:0]        clr_we;
    logic [N-1:0]                abort_q;
    logic                        unused_wdata_hi;

    // Qualify events; transaction events are dropped at memory endpoints.
    assign ev_q[K_TFR]   = ev_tfr;
    assign ev_q[K_BLOCK] = ev_block;
    assign ev_q[K_SRC]   = ev_src_tran & ~src_is_mem;
    assign ev_q[K_DST]   = ev_dst_tran & ~dst_is_mem;
    assign ev_q[K_ERR]   = ev_err;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:N];

    // One raw/mask/status bank per interrupt kind.
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
        dma_irq_bank #(.N(N)) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev_q[k]),
            .mask_we  (mask_we[k]),
            .clr_we   (clr_we[k]),
            .wdata    (reg_wdata[N-1:0]),
            .raw_o    (raw_all[k]),
            .mask_o   (mask_all[k]),
            .status_o (status_all[k]),
            .any_o    (any_all[k])
        );
    end

    dma_irq_regif #(
        .N              (N),
        .DATA_W         (DATA_W),
        .ERR_ON_ILLEGAL (ERR_ON_ILLEGAL)
    ) i_regif (
        .reg_en     (reg_en),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .raw_all    (raw_all),
        .mask_all   (mask_all),
        .status_all (status_all),
        .any_all    (any_all),
        .mask_we    (mask_we),
        .clr_we     (clr_we),
        .reg_rdata  (reg_rdata),
        .reg_err    (reg_err)
    );

    // Abort request: registered copy of the error pulses, aligned with raw.
    always_ff @(posedge clk) begin
        if (!rst_n) abort_q <= '0;
        else        abort_q <= ev_err;
    end

    assign ch_abort     = abort_q;
    assign irq_tfr      = any_all[K_TFR];
    assign irq_block    = any_all[K_BLOCK];
    assign irq_src_tran = any_all[K_SRC];
    assign irq_dst_tran = any_all[K_DST];
    assign irq_err      = any_all[K_ERR];

endmodule

// File: rtl/dma_irq_checker.sv
// Module: dma_irq_checker
// Concurrent checks on the interrupt unit, attached to it by bind below.
// Assumes: the internal raw and mask vectors of the top are visible by name.
module dma_irq_checker
    import dma_irq_pkg::*;
#(
    parameter int N      = 4,
    parameter int DATA_W = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N-1:0]                ev_tfr,
    input logic [N-1:0]                ev_block,
    input logic [N-1:0]                ev_err,
    input logic [N-1:0]                src_is_mem,
    input logic [N-1:0]                dst_is_mem,
    input logic                        reg_en,
    input logic                        reg_we,
    input logic [REG_ADDR_W-1:0]       reg_addr,
    input logic [DATA_W-1:0]           reg_wdata,
    input logic                        reg_err,
    input logic                        irq_block,
    input logic [N-1:0]                ch_abort,
    input logic [NUM_KINDS-1:0][N-1:0] raw_all,
    input logic [NUM_KINDS-1:0][N-1:0] mask_all
);

    // R2: an event bit is recorded on the following edge.
    a_r2_event_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tfr != '0) |=> ((raw_all[0] & $past(ev_tfr)) == $past(ev_tfr)));

    // R6: a block event survives even a simultaneous clear.
    a_r6_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_block != '0) |=> ((raw_all[1] & $past(ev_block)) == $past(ev_block)));

    // R5: clearing block bits with no competing event removes them.
    a_r5_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && reg_addr == 5'h19 && ev_block == '0)
        |=> ((raw_all[1] & $past(reg_wdata[N-1:0])) == '0));

    // R7: no source-transaction bit rises on a memory-source channel.
    a_r7_src_mem_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_is_mem != '0) |=> ((raw_all[2] & ~$past(raw_all[2]) & $past(src_is_mem)) == '0));

    // R7: no destination-transaction bit rises on a memory-destination channel.
    a_r7_dst_mem_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_is_mem != '0) |=> ((raw_all[3] & ~$past(raw_all[3]) & $past(dst_is_mem)) == '0));

    // R8: abort follows the error pulses one cycle later.
    a_r8_abort_follows_err: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err != '0) |=> (ch_abort == $past(ev_err)));

    // R8: no abort without a preceding error.
    a_r8_no_spurious_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err == '0) |=> (ch_abort == '0));

    // R4: block line matches the masked raw vector.
    a_r4_block_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_block == |(raw_all[1] & mask_all[1]));

    // R11: an error response only during an access.
    a_r11_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> reg_en);

endmodule

bind dma_irq_unit dma_irq_checker #(.N(N), .DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_tfr     (ev_tfr),
    .ev_block   (ev_block),
    .ev_err     (ev_err),
    .src_is_mem (src_is_mem),
    .dst_is_mem (dst_is_mem),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_err    (reg_err),
    .irq_block  (irq_block),
    .ch_abort   (ch_abort),
    .raw_all    (raw_all),
    .mask_all   (mask_all)
);

// File: tb/test_dma_irq_unit.sv
`timescale 1ns/1ps
// Bench: sweeps every mask and event pattern per kind on a 4-channel unit,
// plus memory flags, clear patterns, event/clear collisions, abort pulses
// and the full address space for error responses.
module test_dma_irq_unit;

    localparam int N  = 4;
    localparam int DW = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [4:0][N-1:0]   evs = '0;
    logic [N-1:0]        src_mem = '0;
    logic [N-1:0]        dst_mem = '0;
    logic                reg_en = 1'b0;
    logic                reg_we = 1'b0;
    logic [4:0]          reg_addr = '0;
    logic [DW-1:0]       reg_wdata = '0;
    logic [DW-1:0]       reg_rdata;
    logic                reg_err;
    logic                irq_tfr, irq_block, irq_src_tran, irq_dst_tran, irq_err;
    logic [N-1:0]        ch_abort;
    logic [4:0]          irq_vec;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    assign irq_vec = {irq_err, irq_dst_tran, irq_src_tran, irq_block, irq_tfr};

    dma_irq_unit #(.N(N), .DATA_W(DW), .ERR_ON_ILLEGAL(1'b1)) i_dma_irq_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_tfr       (evs[0]),
        .ev_block     (evs[1]),
        .ev_src_tran  (evs[2]),
        .ev_dst_tran  (evs[3]),
        .ev_err       (evs[4]),
        .src_is_mem   (src_mem),
        .dst_is_mem   (dst_mem),
        .reg_en       (reg_en),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .reg_err      (reg_err),
        .irq_tfr      (irq_tfr),
        .irq_block    (irq_block),
        .irq_src_tran (irq_src_tran),
        .irq_dst_tran (irq_dst_tran),
        .irq_err      (irq_err),
        .ch_abort     (ch_abort)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Access: drive on a falling edge, sample the response 1 ns later,
    // release on the next falling edge (a write takes effect in between).
    task automatic acc(input logic [4:0] a, input logic we, input logic [DW-1:0] d,
                       output logic [DW-1:0] rd, output logic err);
        @(negedge clk);
        reg_en = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
        #1;
        rd = reg_rdata; err = reg_err;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] rd; logic err;
        acc(a, 1'b1, d, rd, err);
    endtask

    task automatic rd_val(input logic [4:0] a, output logic [DW-1:0] v);
        logic err;
        acc(a, 1'b0, '0, v, err);
    endtask

    task automatic pulse(input int k, input logic [N-1:0] v);
        @(negedge clk);
        evs[k] = v;
        @(negedge clk);
        evs[k] = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic          e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check("R1 irq lines", {27'd0, irq_vec}, 32'd0);
        check("R1 abort", {28'd0, ch_abort}, 32'd0);
        for (int k = 0; k < 5; k++) begin
            rd_val(5'(k), v);      check("R1 raw", v, 32'd0);
            rd_val(5'(16 + k), v); check("R1 mask", v, 32'd0);
        end

        // R2/R3/R4/R9: every mask against every event pattern, per kind.
        for (int k = 0; k < 5; k++) begin
            for (int m = 0; m < 16; m++) begin
                for (int ev = 0; ev < 16; ev++) begin
                    wr(5'(24 + k), 32'hF);
                    wr(5'(16 + k), 32'(m));
                    pulse(k, 4'(ev));
                    check("R4 line", {31'd0, irq_vec[k]}, {31'd0, |(4'(ev) & 4'(m))});
                    rd_val(5'(k), v);      check("R2 raw", v, 32'(ev));
                    rd_val(5'(8 + k), v);  check("R3 status", v, 32'(ev & m));
                    rd_val(5'(16 + k), v); check("R3 mask", v, 32'(m));
                    rd_val(5'h0F, v);
                    check("R9 summary", v, 32'(((ev & m) != 0) ? (1 << k) : 0));
                end
            end
            wr(5'(24 + k), 32'hF);
            wr(5'(16 + k), 32'h0);
        end

        // R7: memory flags suppress transaction events.
        for (int k = 2; k < 4; k++) begin
            wr(5'(16 + k), 32'hF);
            for (int p = 0; p < 16; p++) begin
                for (int ev = 0; ev < 16; ev++) begin
                    if (k == 2) src_mem = 4'(p); else dst_mem = 4'(p);
                    wr(5'(24 + k), 32'hF);
                    pulse(k, 4'(ev));
                    rd_val(5'(k), v);
                    check("R7 memory suppress", v, 32'(ev & ~p & 15));
                end
            end
            src_mem = '0; dst_mem = '0;
            wr(5'(24 + k), 32'hF);
            wr(5'(16 + k), 32'h0);
        end

        // R5: clear patterns on block kind with all bits set and unmasked.
        wr(5'h11, 32'hF);
        for (int c = 0; c < 16; c++) begin
            pulse(1, 4'hF);
            wr(5'h19, 32'(c));
            rd_val(5'h01, v); check("R5 raw after clear", v, 32'(15 & ~c));
            rd_val(5'h09, v); check("R5 status after clear", v, 32'(15 & ~c));
            check("R5 line", {31'd0, irq_block}, {31'd0, c != 15});
        end
        wr(5'h19, 32'hF);
        wr(5'h11, 32'h0);

        // R6: event and clear on the same edge; event wins on its bits.
        pulse(0, 4'hF);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 5'h18; reg_wdata = 32'hF;
        evs[0] = 4'b0101;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; evs[0] = '0;
        rd_val(5'h00, v); check("R6 event beats clear", v, 32'h5);
        wr(5'h18, 32'hF);

        // R8: abort pulse follows each error pattern for one cycle.
        for (int ev = 0; ev < 16; ev++) begin
            @(negedge clk);
            evs[4] = 4'(ev);
            @(negedge clk);
            evs[4] = '0;
            check("R8 abort pulse", {28'd0, ch_abort}, 32'(ev));
            @(negedge clk);
            check("R8 abort released", {28'd0, ch_abort}, 32'd0);
        end
        rd_val(5'h04, v); check("R8 error raw", v, 32'hF);
        wr(5'h1C, 32'hF);

        // R10: writes to read-only addresses change nothing; clear reads 0.
        wr(5'h00, 32'hF);
        rd_val(5'h00, v); check("R10 raw write ignored", v, 32'd0);
        wr(5'h08, 32'hF);
        rd_val(5'h08, v); check("R10 status write ignored", v, 32'd0);
        wr(5'h0F, 32'hFF);
        rd_val(5'h0F, v); check("R10 summary write ignored", v, 32'd0);
        wr(5'h10, 32'hFFFF_FFFF);
        rd_val(5'h10, v); check("R10 mask upper bits", v, 32'hF);
        rd_val(5'h18, v); check("R10 clear reads zero", v, 32'd0);
        wr(5'h10, 32'h0);

        // R11: error response over the whole address space, read and write.
        for (int a = 0; a < 32; a++) begin
            logic bad;
            bad = ((a & 7) >= 5) && (a != 15);
            acc(5'(a), 1'b0, '0, v, e);
            check("R11 read err", {31'd0, e}, {31'd0, bad});
            acc(5'(a), 1'b1, '0, v, e);
            check("R11 write err", {31'd0, e}, {31'd0, bad});
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule